// File: doc/BRIEF.md
# SPI Addressed GPIO Expander

This block is an SPI slave that gives a host access to a general-purpose I/O port through a small byte-addressed register file. The host lowers chip select and shifts bytes in mode 0, most significant bit first. The first byte is an opcode that carries a fixed family code, a three-bit device address and a read/write flag. The second byte is a register pointer. Each further byte is a data byte: on a write it is stored in the register the pointer names, and on a read the slave shifts the addressed register out on MISO.

Up to eight of these slaves can share one chip select. When the hardware-addressing bit in the configuration register is set, a slave only answers opcodes whose address field matches its address pins. While that bit is clear, the slave answers any address. A second configuration bit controls bursts. While it is clear, the pointer advances after every data byte, so a burst walks through the register map. While it is set, the pointer stays on one register.

The direction, output-latch, pull-up and input-polarity registers drive the pads. A pad is an output when its direction bit is 0, and it then drives the latch value. The SPI pins and the pad inputs are resynchronised to the system clock, and all state changes on that clock.

Top module: `gpx_expander`

## Requirements
- R1: Opcode decoding. An opcode whose upper nibble is not 4'b0100 deselects the slave for the rest of the transfer. Its writes have no effect and it drives no MISO data. Opcode bits 3:1 are the device address and bit 0 is 1 for a read.
- R2: Byte phases. Byte two of a transfer is the register pointer. On a write, each following byte is stored at the pointer. On a read, the register named by the pointer is shifted out on MISO in the byte that follows, MSB first. MISO changes after a falling SCK edge and is sampled on the rising edge.
- R3: Reset values. The direction register (0x00) resets to all ones, and every other register resets to zero. So after reset pad_oe, pad_out and pull_en are all 0 and miso_oe is 0.
- R4: Direction register (0x00). A bit of 1 makes the pin an input and a bit of 0 makes it an output. pad_oe is the bitwise inverse of the register.
- R5: Output latch (0x0A). pad_out follows the latch. A write to the port address 0x09 also stores into the latch. Reading 0x0A returns the latch value and not the pin level.
- R6: Port and polarity. Reading the port address 0x09 returns the synchronised pad_in XOR the input-polarity register (0x01).
- R7: Pull-up register (0x06). pull_en is the register value.
- R8: Sequential mode. Configuration register 0x05 bit 5 selects the pointer behaviour. While it is clear, the pointer increments after every data byte. While it is set, the pointer stays fixed. Registers 0x02, 0x03, 0x04 and 0x05 read back the value last written.
- R9: Hardware addressing. Configuration bit 3 controls address matching. While it is set, only opcodes whose bits 3:1 equal hw_addr are served. While it is clear, every address field is accepted.
- R10: Reserved addresses. Addresses 0x07, 0x08 and every address above 0x0A read as zero. Writes to them change no register.
- R11: Aborted bytes. When chip select rises in the middle of a byte, that byte is discarded and no register changes.
- R12: MISO enable. miso_oe is 1 only during the data bytes of a read that the slave accepted. It is 0 during the opcode and pointer bytes, during writes and while the slave is deselected. miso is 0 whenever miso_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Shared active-low chip select |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Drive enable for the MISO pad |
| hw_addr | input | 3 | Device address pins |
| pad_in | input | PORT_W | Pad input levels |
| pad_out | output | PORT_W | Pad output values |
| pad_oe | output | PORT_W | Pad output enables, 1 means drive |
| pull_en | output | PORT_W | Pad pull-up enables |

## Verification
A register write reaches pad_oe, pad_out or pull_en on the third rising clock edge after the SCK rising edge that completes the data byte. That delay is two synchroniser stages and one register. The bench model applies each write exactly three rising edges after it raises that SCK edge, and it compares the pad outputs on every falling clock edge. Read data is loaded three edges after the pointer byte ends and shifted three edges after each falling SCK edge. The bench samples MISO and miso_oe one clock before it raises SCK, when at least five clocks of settling have passed.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   localparam int BYTE_W  = 8;
   localparam int HWA_W   = 3;
   localparam int BCNT_W  = $clog2(BYTE_W);

   typedef logic [BYTE_W-1:0] byte_t;

   localparam logic [3:0] OPC_FAMILY = 4'b0100;

   localparam byte_t RA_DIR  = 8'h00;
   localparam byte_t RA_POL  = 8'h01;
   localparam byte_t RA_IEN  = 8'h02;
   localparam byte_t RA_CMP  = 8'h03;
   localparam byte_t RA_ICTL = 8'h04;
   localparam byte_t RA_CFG  = 8'h05;
   localparam byte_t RA_PUP  = 8'h06;
   localparam byte_t RA_IFLG = 8'h07;
   localparam byte_t RA_ICAP = 8'h08;
   localparam byte_t RA_PORT = 8'h09;
   localparam byte_t RA_LAT  = 8'h0A;

   localparam int CFG_SEQ_OFF_BIT = 5;
   localparam int CFG_HWA_EN_BIT  = 3;

   typedef enum logic [1:0] {
      PH_OPC  = 2'd0,
      PH_REG  = 2'd1,
      PH_DATA = 2'd2,
      PH_SKIP = 2'd3
   } phase_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] st [STAGES];

   initial begin
      assert (STAGES >= 2) else $fatal(1, "gpx_sync: STAGES must be at least 2");
      assert (WIDTH >= 1) else $fatal(1, "gpx_sync: WIDTH must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) st[s] <= RST_VAL;
      end else begin
         st[0] <= d;
         for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/gpx_spi_frontend.sv
module gpx_spi_frontend
   import gpx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sck_s,
   input  logic             mosi_s,
   input  logic             cs_s,
   input  logic [HWA_W-1:0] hw_addr,
   input  logic             cfg_seq_off,
   input  logic             cfg_hwa_en,
   input  byte_t            rd_data,
   output byte_t            rd_addr,
   output logic             wr_en,
   output byte_t            wr_addr,
   output byte_t            wr_data,
   output logic             miso,
   output logic             miso_oe
);
   logic              sck_q;
   logic              sck_rise, sck_fall;
   logic [BCNT_W-1:0] bitcnt_q;
   logic [BYTE_W-2:0] rx_sh_q;
   byte_t             rx_byte;
   byte_t             tx_sh_q;
   byte_t             ptr_q, ptr_next;
   phase_e            phase_q;
   logic              is_read_q;
   logic              byte_done;
   logic              addr_ok;

   assign sck_rise  = sck_s & ~sck_q;
   assign sck_fall  = ~sck_s & sck_q;
   assign rx_byte   = {rx_sh_q, mosi_s};
   assign byte_done = sck_rise & ~cs_s & (bitcnt_q == BCNT_W'(BYTE_W-1));
   assign addr_ok   = (rx_byte[7:4] == OPC_FAMILY) &&
                      (!cfg_hwa_en || (rx_byte[HWA_W:1] == hw_addr));
   assign ptr_next  = cfg_seq_off ? ptr_q : ptr_q + 8'd1;
   assign rd_addr   = (phase_q == PH_REG) ? rx_byte : ptr_next;

   assign wr_en   = byte_done && (phase_q == PH_DATA) && !is_read_q;
   assign wr_addr = ptr_q;
   assign wr_data = rx_byte;

   assign miso_oe = ~cs_s & is_read_q & (phase_q == PH_DATA);
   assign miso    = miso_oe & tx_sh_q[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitcnt_q  <= '0;
         rx_sh_q   <= '0;
         tx_sh_q   <= '0;
         ptr_q     <= '0;
         phase_q   <= PH_OPC;
         is_read_q <= 1'b0;
      end else if (cs_s) begin
         bitcnt_q  <= '0;
         phase_q   <= PH_OPC;
         is_read_q <= 1'b0;
      end else begin
         if (sck_rise) begin
            rx_sh_q  <= rx_byte[BYTE_W-2:0];
            bitcnt_q <= bitcnt_q + 1'b1;
         end
         if (sck_fall && (bitcnt_q != '0)) begin
            tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b0};
         end
         if (byte_done) begin
            case (phase_q)
               PH_OPC: begin
                  phase_q   <= addr_ok ? PH_REG : PH_SKIP;
                  is_read_q <= rx_byte[0];
               end
               PH_REG: begin
                  ptr_q   <= rx_byte;
                  phase_q <= PH_DATA;
                  if (is_read_q) tx_sh_q <= rd_data;
               end
               PH_DATA: begin
                  ptr_q <= ptr_next;
                  if (is_read_q) tx_sh_q <= rd_data;
               end
               default: phase_q <= PH_SKIP;
            endcase
         end
      end
   end

   AST_FOREIGN_OPCODE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && phase_q == PH_OPC && rx_byte[7:4] != OPC_FAMILY) |=> (phase_q != PH_REG)); // R1
   AST_RELEASE_CLEARS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> (bitcnt_q == '0 && phase_q == PH_OPC)); // R11
   AST_MISO_ENABLE_AFTER_POINTER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(miso_oe) |-> $past(byte_done)); // R12
   AST_POINTER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && phase_q == PH_DATA && cfg_seq_off) |=> $stable(ptr_q)); // R8
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
   import gpx_pkg::*;
#(
   parameter int PORT_W = 8,
   parameter logic [PORT_W-1:0] DIR_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  byte_t             wr_addr,
   input  byte_t             wr_data,
   input  byte_t             rd_addr,
   input  logic [PORT_W-1:0] pin_s,
   output byte_t             rd_data,
   output logic              cfg_seq_off,
   output logic              cfg_hwa_en,
   output logic [PORT_W-1:0] pad_out,
   output logic [PORT_W-1:0] pad_oe,
   output logic [PORT_W-1:0] pull_en
);
   logic [PORT_W-1:0] dir_q, pol_q, ien_q, cmp_q, ictl_q, pup_q, lat_q;
   byte_t             cfg_q;
   logic [PORT_W-1:0] wd;

   assign wd = wr_data[PORT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= DIR_RST;
         pol_q  <= '0;
         ien_q  <= '0;
         cmp_q  <= '0;
         ictl_q <= '0;
         cfg_q  <= '0;
         pup_q  <= '0;
         lat_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            RA_DIR:  dir_q  <= wd;
            RA_POL:  pol_q  <= wd;
            RA_IEN:  ien_q  <= wd;
            RA_CMP:  cmp_q  <= wd;
            RA_ICTL: ictl_q <= wd;
            RA_CFG:  cfg_q  <= wr_data;
            RA_PUP:  pup_q  <= wd;
            RA_PORT: lat_q  <= wd;
            RA_LAT:  lat_q  <= wd;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (rd_addr)
         RA_DIR:  rd_data = BYTE_W'(dir_q);
         RA_POL:  rd_data = BYTE_W'(pol_q);
         RA_IEN:  rd_data = BYTE_W'(ien_q);
         RA_CMP:  rd_data = BYTE_W'(cmp_q);
         RA_ICTL: rd_data = BYTE_W'(ictl_q);
         RA_CFG:  rd_data = cfg_q;
         RA_PUP:  rd_data = BYTE_W'(pup_q);
         RA_PORT: rd_data = BYTE_W'(pin_s ^ pol_q);
         RA_LAT:  rd_data = BYTE_W'(lat_q);
         default: rd_data = '0;
      endcase
   end

   assign cfg_seq_off = cfg_q[CFG_SEQ_OFF_BIT];
   assign cfg_hwa_en  = cfg_q[CFG_HWA_EN_BIT];

   generate
      for (genvar p = 0; p < PORT_W; p++) begin : g_pin
         assign pad_oe[p]  = ~dir_q[p];
         assign pad_out[p] = lat_q[p];
         assign pull_en[p] = pup_q[p];
      end
   endgenerate

   AST_RESERVED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr > RA_LAT) |=> ($stable(dir_q) && $stable(lat_q) && $stable(cfg_q) && $stable(pup_q))); // R10
   AST_DIRECTION_TO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == RA_DIR) |=> (pad_oe == ~$past(wd))); // R4
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
   import gpx_pkg::*;
#(
   parameter int PORT_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter logic [PORT_W-1:0] DIR_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              mosi,
   input  logic              cs_n,
   output logic              miso,
   output logic              miso_oe,
   input  logic [HWA_W-1:0]  hw_addr,
   input  logic [PORT_W-1:0] pad_in,
   output logic [PORT_W-1:0] pad_out,
   output logic [PORT_W-1:0] pad_oe,
   output logic [PORT_W-1:0] pull_en
);
   localparam int SPI_W = 3;

   logic [SPI_W-1:0]  spi_s;
   logic [PORT_W-1:0] pin_s;
   byte_t             rd_addr, rd_data, wr_addr, wr_data;
   logic              wr_en, cfg_seq_off, cfg_hwa_en;

   initial begin
      assert (PORT_W >= 1 && PORT_W <= BYTE_W)
         else $fatal(1, "gpx_expander: PORT_W must lie in 1..BYTE_W");
   end

   gpx_sync #(.WIDTH(SPI_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_spi_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sck, mosi}), .q(spi_s)
   );

   gpx_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_s)
   );

   gpx_spi_frontend u_front (
      .clk(clk), .rst_n(rst_n),
      .sck_s(spi_s[1]), .mosi_s(spi_s[0]), .cs_s(spi_s[2]),
      .hw_addr(hw_addr), .cfg_seq_off(cfg_seq_off), .cfg_hwa_en(cfg_hwa_en),
      .rd_data(rd_data), .rd_addr(rd_addr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .miso(miso), .miso_oe(miso_oe)
   );

   gpx_regfile #(.PORT_W(PORT_W), .DIR_RST(DIR_RST)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .pin_s(pin_s), .rd_data(rd_data),
      .cfg_seq_off(cfg_seq_off), .cfg_hwa_en(cfg_hwa_en),
      .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en)
   );
endmodule

// File: tb/gpx_expander_test.sv
module gpx_expander_test;
   localparam int HALF = 8;

   logic       clk = 1'b0, rst_n = 1'b0, sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
   logic [2:0] hw_addr = 3'd0;
   logic [7:0] pad_in = 8'h00;
   logic       miso, miso_oe;
   logic [7:0] pad_out, pad_oe, pull_en;

   int  checks = 0, errors = 0;
   bit  cmp_en = 0, done = 0;

   logic [7:0] m_dir, m_pol, m_ien, m_cmp, m_ictl, m_cfg, m_pup, m_lat;
   bit         pend_v = 0;
   logic [7:0] pend_a, pend_d;
   logic [7:0] wbuf [8];

   always #2 clk = ~clk;

   gpx_expander uut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n),
      .miso(miso), .miso_oe(miso_oe), .hw_addr(hw_addr), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en)
   );

   task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] m_read(input logic [7:0] a);
      case (a)
         8'h00: return m_dir;
         8'h01: return m_pol;
         8'h02: return m_ien;
         8'h03: return m_cmp;
         8'h04: return m_ictl;
         8'h05: return m_cfg;
         8'h06: return m_pup;
         8'h09: return pad_in ^ m_pol;
         8'h0A: return m_lat;
         default: return 8'h00;
      endcase
   endfunction

   task automatic m_write(input logic [7:0] a, input logic [7:0] d);
      case (a)
         8'h00: m_dir = d;
         8'h01: m_pol = d;
         8'h02: m_ien = d;
         8'h03: m_cmp = d;
         8'h04: m_ictl = d;
         8'h05: m_cfg = d;
         8'h06: m_pup = d;
         8'h09, 8'h0A: m_lat = d;
         default: ;
      endcase
   endtask

   always @(negedge clk) begin
      if (cmp_en && !done) begin
         chk("R4", "pad_oe", pad_oe, ~m_dir);
         chk("R5", "pad_out", pad_out, m_lat);
         chk("R7", "pull_en", pull_en, m_pup);
      end
   end

   task automatic spi_byte(input logic [7:0] tx, input int nbits,
                           output logic [7:0] rx, output bit oe_any, output bit oe_all);
      rx = 8'h00; oe_any = 0; oe_all = 1;
      for (int i = 7; i >= 8 - nbits; i--) begin
         @(negedge clk);
         mosi = tx[i];
         repeat (HALF - 1) @(negedge clk);
         rx[i] = miso;
         oe_any = oe_any | miso_oe;
         oe_all = oe_all & miso_oe;
         sck = 1'b1;
         if (i == 0 && pend_v) begin
            repeat (3) @(posedge clk);
            m_write(pend_a, pend_d);
            pend_v = 0;
            repeat (HALF - 2) @(negedge clk);
         end else begin
            repeat (HALF) @(negedge clk);
         end
         sck = 1'b0;
      end
   endtask

   task automatic cs_lo();
      @(negedge clk);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic cs_hi();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (2 * HALF) @(negedge clk);
   endtask

   function automatic logic [7:0] opc(input logic [2:0] a, input bit rd);
      return {4'b0100, a, rd};
   endfunction

   task automatic xfer(input logic [7:0] op, input logic [7:0] ra, input int n, input string tag);
      logic [7:0] got, expv, a;
      bit any, all, sel, rd, seq_off;
      sel = (op[7:4] == 4'b0100) && (!m_cfg[3] || op[3:1] == hw_addr);
      rd  = op[0];
      cs_lo();
      spi_byte(op, 8, got, any, all);
      chk("R12", "miso_oe during opcode", 8'(any), 8'h00);
      spi_byte(ra, 8, got, any, all);
      chk("R12", "miso_oe during pointer", 8'(any), 8'h00);
      a = ra;
      for (int k = 0; k < n; k++) begin
         seq_off = m_cfg[5];
         if (!rd && sel) begin
            pend_v = 1; pend_a = a; pend_d = wbuf[k];
         end
         expv = m_read(a);
         spi_byte(rd ? 8'h00 : wbuf[k], 8, got, any, all);
         if (rd && sel) begin
            chk(tag, "read data", got, expv);
            chk("R12", "miso_oe in read data", 8'(all), 8'h01);
         end else begin
            chk("R12", "miso_oe idle", 8'(any), 8'h00);
         end
         if (!seq_off) a = a + 8'd1;
      end
      cs_hi();
   endtask

   task automatic wr1(input logic [2:0] ha, input logic [7:0] ra, input logic [7:0] d, input string tag);
      wbuf[0] = d;
      xfer(opc(ha, 0), ra, 1, tag);
   endtask

   initial begin
      logic [7:0] junk;
      bit a1, a2;
      m_dir = 8'hFF; m_pol = 0; m_ien = 0; m_cmp = 0; m_ictl = 0;
      m_cfg = 0; m_pup = 0; m_lat = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R3", "pad_oe after reset", pad_oe, 8'h00);
      chk("R3", "pad_out after reset", pad_out, 8'h00);
      chk("R3", "pull_en after reset", pull_en, 8'h00);
      chk("R3", "miso_oe after reset", 8'(miso_oe), 8'h00);
      cmp_en = 1;
      xfer(opc(0, 1), 8'h00, 1, "R3");

      pad_in = 8'h3C;
      wr1(0, 8'h00, 8'h0F, "R4");
      wr1(0, 8'h0A, 8'hA5, "R5");
      xfer(opc(0, 1), 8'h0A, 1, "R5");
      xfer(opc(0, 1), 8'h09, 1, "R6");
      xfer(opc(0, 1), 8'h09, 1, "R2");
      wr1(0, 8'h01, 8'hFF, "R6");
      xfer(opc(0, 1), 8'h09, 1, "R6");
      wr1(0, 8'h01, 8'h00, "R6");
      wr1(0, 8'h06, 8'h81, "R7");
      chk("R7", "pull_en after write", pull_en, 8'h81);
      wr1(0, 8'h09, 8'h5A, "R5");

      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      xfer(opc(0, 0), 8'h02, 3, "R8");
      xfer(opc(0, 1), 8'h00, 7, "R8");
      xfer(opc(0, 1), 8'h09, 2, "R8");

      wr1(0, 8'h05, 8'h20, "R8");
      xfer(opc(0, 1), 8'h0A, 3, "R8");
      wbuf[0] = 8'h12; wbuf[1] = 8'h34;
      xfer(opc(0, 0), 8'h06, 2, "R8");
      chk("R8", "pull_en after held burst", pull_en, 8'h34);

      hw_addr = 3'd5;
      xfer(opc(2, 1), 8'h0A, 1, "R9");
      wr1(0, 8'h05, 8'h28, "R9");
      xfer(opc(2, 1), 8'h0A, 1, "R9");
      wr1(2, 8'h0A, 8'hFF, "R9");
      xfer(opc(5, 1), 8'h0A, 1, "R9");
      wr1(5, 8'h0A, 8'hC3, "R9");
      chk("R9", "pad_out after matching write", pad_out, 8'hC3);

      wbuf[0] = 8'h00;
      xfer(8'h5A, 8'h0A, 1, "R1");
      xfer(8'h6B, 8'h0A, 1, "R1");
      xfer(opc(5, 1), 8'h0A, 1, "R1");

      wr1(5, 8'h0B, 8'h77, "R10");
      wr1(5, 8'h07, 8'h77, "R10");
      wr1(5, 8'hFF, 8'h77, "R10");
      xfer(opc(5, 1), 8'h07, 1, "R10");
      xfer(opc(5, 1), 8'h08, 1, "R10");
      xfer(opc(5, 1), 8'h0B, 1, "R10");
      xfer(opc(5, 1), 8'hFF, 1, "R10");

      cs_lo();
      spi_byte(opc(5, 0), 8, junk, a1, a2);
      spi_byte(8'h0A, 8, junk, a1, a2);
      spi_byte(8'h0F, 4, junk, a1, a2);
      cs_hi();
      xfer(opc(5, 1), 8'h0A, 1, "R11");
      chk("R11", "pad_out after aborted byte", pad_out, 8'hC3);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule